// File: doc/BRIEF.md
# Encoded I2C clock divider

This block sets the bit rate of an I2C master. It takes a 6-bit divider code and turns it into a division ratio of the system clock. A free-running counter then marks every half of an SCL period. Each half-period ends with a one-cycle tick, and a phase flag shows which half of the SCL period is in progress. A bit engine downstream uses the tick as its edge point and the phase flag as its high/low indication.

The code is not a binary count. It splits into a 3-bit prescale selector and a 3-bit exponent. The selector indexes a non-monotonic table. A small filter-sampling term is added to the table entry, and the sum is shifted left by an amount set by the exponent. The sampling rate is fixed at its default, so the sampling term is a constant that is shifted right as the exponent grows. A build parameter selects a doubled-table variant for faster system clocks. The code is sampled again only at the end of a half-period, so a change never cuts a half-period short. When the enable is low, the counter and the phase are held at zero and no ticks are produced.

Top module: `scl_rate_gen`

## Requirements
- R1: The prescale selector is {div_code[5], div_code[1], div_code[0]} (div_code[5] is its MSB), and the exponent is div_code[4:2].
- R2: With DOUBLED=0, the selector values 0..7 pick the prescale entries 9, 10, 12, 15, 5, 6, 7 and 8. The sampling term is 6 >> exponent, and the full division ratio is (entry + term) << (exponent + 1).
- R3: With DOUBLED=1, every entry is doubled, the sampling term has its LSB cleared, and the ratio is (2*entry + term) << (exponent + 4).
- R4: While enabled, consecutive scl_tick pulses are exactly ratio/2 clock cycles apart, and each pulse lasts one cycle.
- R5: scl_phase toggles on every cycle in which scl_tick is high and nowhere else while the block stays enabled.
- R6: A new div_code is sampled only at the end of a half-period. The half-period in progress finishes with its old length, and the next one uses the new code.
- R7: While en is low, scl_tick and scl_phase read 0 from the next cycle on, and the counter restarts from zero.
- R8: While rst_n is low, scl_tick and scl_phase are 0 from the next edge on, even with en high.
- R9: After en rises, or after reset is released with en high, the first tick comes on the ratio/2-th enabled clock edge. The phase flag is 1 after that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the counter and phase at zero |
| div_code | input | 6 | Encoded divider code |
| scl_tick | output | 1 | One-cycle pulse at each SCL edge point |
| scl_phase | output | 1 | Current SCL half-period (toggles on each tick) |

## Verification
The bound checker watches several rules on every cycle:
- no tick and a zero phase after an idle cycle;
- no phase change without a tick while running;
- no back-to-back ticks;
- a tick only after an enabled cycle;
- no gap between ticks longer than the largest half-period the code space allows.

The exact spacing for each code depends on the scrambled field split and the table, so only the bench can show it. The bench sweeps all 64 codes in the normal variant and the small-exponent codes in the doubled one. Only directed scenarios can show three further behaviours:
- a code change in mid-period that is deferred;
- the count that restarts after a disable;
- the timing of the first tick after an enable.

// File: rtl/scl_div_pkg.sv
// Shared definitions for the encoded SCL divider.
// Assumes a 6-bit code with a fixed filter sampling rate (default value),
// so the sampling term at exponent 0 is a constant.
package scl_div_pkg;

    localparam int CODE_W         = 6;
    localparam int FLD_W          = 3;
    localparam int BASE_FILT_TERM = 6;

    typedef struct packed {
        logic [FLD_W-1:0] pre_sel;   // prescale table index
        logic [FLD_W-1:0] exp_sel;   // power-of-two exponent
    } div_fields_t;

    // Separate the scrambled code into selector and exponent fields.
    function automatic div_fields_t split_code(input logic [CODE_W-1:0] code);
        div_fields_t f;
        f.pre_sel = {code[5], code[1], code[0]};
        f.exp_sel = code[4:2];
        return f;
    endfunction

    // Non-monotonic prescale table of the normal variant.
    function automatic int unsigned prescale(input logic [FLD_W-1:0] idx);
        case (idx)
            3'd0:    return 9;
            3'd1:    return 10;
            3'd2:    return 12;
            3'd3:    return 15;
            3'd4:    return 5;
            3'd5:    return 6;
            3'd6:    return 7;
            default: return 8;
        endcase
    endfunction

    // Sampling term, halved for each exponent step.
    function automatic int unsigned filt_term(input logic [FLD_W-1:0] e);
        return BASE_FILT_TERM >> e;
    endfunction

    // Half of the division ratio; used only to size counters.
    function automatic int unsigned half_count(input logic [CODE_W-1:0] code,
                                               input bit dbl);
        div_fields_t  f;
        int unsigned  s;
        f = split_code(code);
        if (dbl) begin
            s = (prescale(f.pre_sel) << 1) + (filt_term(f.exp_sel) & ~32'd1);
            return s << (f.exp_sel + 3);
        end
        s = prescale(f.pre_sel) + filt_term(f.exp_sel);
        return s << f.exp_sel;
    endfunction

    // Largest half-period over the whole code space.
    function automatic int unsigned max_half(input bit dbl);
        int unsigned m;
        int unsigned h;
        m = 0;
        for (int c = 0; c < (1 << CODE_W); c++) begin
            h = half_count(CODE_W'(c), dbl);
            if (h > m) m = h;
        end
        return m;
    endfunction

endpackage

// File: rtl/scl_code_hold.sv
// Holds the divider code that is in force.
// Assumes load is high while idle and on the last cycle of each half-period,
// so a code change never alters a half-period already running.
module scl_code_hold
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] code_q
);

    // Capture the external code only at permitted instants.
    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= '0;
        else if (load) code_q <= code_in;
    end

endmodule

// File: rtl/scl_ratio_decode.sv
// Turns the active code into the terminal count of a half-period (ratio/2 - 1).
// Purely combinational; DOUBLED picks the fast-clock table variant.
module scl_ratio_decode
    import scl_div_pkg::*;
#(
    parameter bit DOUBLED = 1'b0,
    parameter int CNT_W   = 12
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  half_m1
);

    localparam int HW    = CNT_W + 1;
    localparam int SUM_W = 6;
    localparam int SH_W  = 4;

    div_fields_t      fld;
    logic [SUM_W-1:0] base_sum;
    logic [SH_W-1:0]  shamt;
    logic [HW-1:0]    half_full;

    assign fld = split_code(code);

    generate
        if (DOUBLED) begin : g_doubled
            // Doubled entries, even sampling term, shift by exponent + 3.
            always_comb begin
                base_sum = SUM_W'((prescale(fld.pre_sel) << 1)
                                  + (filt_term(fld.exp_sel) & ~32'd1));
                shamt    = SH_W'(fld.exp_sel) + SH_W'(3);
            end
        end else begin : g_normal
            // Plain entries, shift by exponent only (ratio shift minus one).
            always_comb begin
                base_sum = SUM_W'(prescale(fld.pre_sel) + filt_term(fld.exp_sel));
                shamt    = SH_W'(fld.exp_sel);
            end
        end
    endgenerate

    // Scale the sum and form the terminal count.
    always_comb begin
        half_full = HW'(base_sum) << shamt;
        half_m1   = CNT_W'(half_full - HW'(1));
    end

endmodule

// File: rtl/scl_half_counter.sv
// Counts clock cycles up to a terminal value, then emits a one-cycle tick
// and flips the phase. Assumes half_m1 is stable within a half-period.
module scl_half_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] half_m1,
    output logic             wrap,
    output logic             tick,
    output logic             phase
);

    logic [CNT_W-1:0] cnt_q;

    // Last cycle of the current half-period.
    assign wrap = en && (cnt_q == half_m1);

    // Advance the count, pulse the tick and flip the phase at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            tick  <= 1'b0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tick  <= 1'b1;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/scl_rate_gen.sv
// Encoded SCL rate generator: code hold, ratio decode and half-period counter.
// Assumes a synchronous active-low reset and a code driven from clk's domain.
module scl_rate_gen
    import scl_div_pkg::*;
#(
    parameter bit DOUBLED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] div_code,
    output logic              scl_tick,
    output logic              scl_phase
);

    localparam int unsigned MAX_HALF = max_half(DOUBLED);
    localparam int          CNT_W    = $clog2(MAX_HALF + 1);

    logic [CODE_W-1:0] active_code;
    logic [CNT_W-1:0]  half_m1;
    logic              wrap;
    logic              code_load;

    // Reload the code while idle or when a half-period ends.
    assign code_load = !en || wrap;

    scl_code_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (code_load),
        .code_in (div_code),
        .code_q  (active_code)
    );

    scl_ratio_decode #(
        .DOUBLED (DOUBLED),
        .CNT_W   (CNT_W)
    ) u_decode (
        .code    (active_code),
        .half_m1 (half_m1)
    );

    scl_half_counter #(
        .CNT_W   (CNT_W)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .half_m1 (half_m1),
        .wrap    (wrap),
        .tick    (scl_tick),
        .phase   (scl_phase)
    );

endmodule

// File: rtl/scl_rate_gen_chk.sv
// Cycle-level checks on the rate generator's outputs, bound to every instance.
// Assumes MAX_HALF is the largest half-period the code space can produce.
module scl_rate_gen_chk #(
    parameter int unsigned MAX_HALF = 2688
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_tick,
    input logic scl_phase
);

    localparam int GW = $clog2(MAX_HALF + 2) + 1;

    logic [GW-1:0] gap_q;

    // Cycles since the last visible tick, saturating, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || scl_tick) gap_q <= '0;
        else if (gap_q != '1)          gap_q <= gap_q + GW'(1);
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_tick && !scl_phase));

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !scl_tick) |-> $stable(scl_phase));

    // R5
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_tick |-> (scl_phase != $past(scl_phase)));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_tick |=> !scl_tick);

    // R7
    tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_tick |-> $past(en));

    // R4
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GW'(MAX_HALF));

endmodule

bind scl_rate_gen scl_rate_gen_chk #(.MAX_HALF(MAX_HALF)) u_rate_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .scl_tick  (scl_tick),
    .scl_phase (scl_phase)
);

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en0 = 1'b0, en1 = 1'b0;
    logic [5:0] code0 = '0, code1 = '0;
    logic       tick0, phase0, tick1, phase1;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;   // 250 MHz

    scl_rate_gen #(.DOUBLED(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .en(en0), .div_code(code0),
        .scl_tick(tick0), .scl_phase(phase0));

    scl_rate_gen #(.DOUBLED(1'b1)) dut_dbl (
        .clk(clk), .rst_n(rst_n), .en(en1), .div_code(code1),
        .scl_tick(tick1), .scl_phase(phase1));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected half-period from the requirement arithmetic.
    function automatic int exp_half(input bit dbl, input int code);
        int a, b, t;
        a = (((code >> 5) & 1) << 2) | (code & 3);
        b = (code >> 2) & 7;
        case (a)
            0: t = 9;  1: t = 10; 2: t = 12; 3: t = 15;
            4: t = 5;  5: t = 6;  6: t = 7;  default: t = 8;
        endcase
        if (dbl) return ((2 * t) + ((6 >> b) & 6)) << (b + 3);
        return (t + (6 >> b)) << b;
    endfunction

    // Count falling edges until the selected tick is seen.
    task automatic wait_tick(input bit sel, output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!(sel ? tick1 : tick0) && gap < 100000);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int g1, g2, h, p;

        // R8: reset dominates even with en high.
        en0 = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(tick0 == 1'b0 && phase0 == 1'b0, "R8 outputs in reset", {tick0, phase0}, 0);
        end
        rst_n = 1'b1;
        // R9: first tick after release with code 0 (half 15).
        wait_tick(0, g1);
        check(g1 == exp_half(0, 0), "R9 first tick after reset", g1, exp_half(0, 0));
        check(phase0 == 1'b1, "R9 phase after first tick", phase0, 1);

        // R1 R2 R4 R5: sweep every code of the normal variant.
        for (int c = 0; c < 64; c++) begin
            code0 = 6'(c);
            h = exp_half(0, c);
            wait_tick(0, g1);          // end of the half-period using the old code
            p = phase0;
            wait_tick(0, g1);
            check(g1 == h, $sformatf("R1 R2 code %0d spacing", c), g1, h);
            check(phase0 != p[0], $sformatf("R5 code %0d phase flip", c), phase0, !p[0]);
            wait_tick(0, g2);
            check(g2 == h, $sformatf("R4 code %0d repeat spacing", c), g2, h);
        end

        // R6: a code change in mid-period does not shorten it.
        code0 = 6'd31;
        wait_tick(0, g1);
        wait_tick(0, g1);
        repeat (100) @(negedge clk);
        code0 = 6'd0;
        wait_tick(0, g1);
        check(g1 == exp_half(0, 31) - 100, "R6 old half-period kept", g1, exp_half(0, 31) - 100);
        wait_tick(0, g2);
        check(g2 == exp_half(0, 0), "R6 new code after wrap", g2, exp_half(0, 0));

        // R7: disable mid-period, outputs quiet, restart from zero.
        wait_tick(0, g1);
        repeat (5) @(negedge clk);
        en0 = 1'b0;
        code0 = 6'h08;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(tick0 == 1'b0 && phase0 == 1'b0, "R7 idle outputs", {tick0, phase0}, 0);
        end
        en0 = 1'b1;
        wait_tick(0, g1);
        check(g1 == exp_half(0, 8), "R7 R9 restart count", g1, exp_half(0, 8));
        check(phase0 == 1'b1, "R9 phase after restart tick", phase0, 1);
        en0 = 1'b0;

        // R3: doubled variant, codes with small exponents.
        code1 = 6'd0;
        @(negedge clk);
        en1 = 1'b1;
        wait_tick(1, g1);
        check(g1 == exp_half(1, 0), "R3 R9 doubled first tick", g1, exp_half(1, 0));
        for (int c = 0; c < 64; c++) begin
            if (((c >> 2) & 7) <= 2) begin
                code1 = 6'(c);
                h = exp_half(1, c);
                wait_tick(1, g1);
                wait_tick(1, g1);
                check(g1 == h, $sformatf("R3 doubled code %0d spacing", c), g1, h);
                wait_tick(1, g2);
                check(g2 == h, $sformatf("R3 R4 doubled code %0d repeat", c), g2, h);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule